// File: doc/BRIEF.md
# Bus Master Transfer Sequencer

This block sits on the master side of a shared system bus. It turns local read and write requests into the bus transfer type, address, direction, size and protection outputs. A request can be a single access or an incrementing burst of up to 2^CW-1 beats. The block follows its grant input and the slave wait response. It enables its shared outputs only while it owns the bus, and it fills idle and handover slots with address-only cycles. The slave may end a burst early or abort it through an error and a last input.

The bus is modelled with one system clock and a phase input, `phase_hi`. The sequencer decides only on an edge where `phase_hi` is 1, called a step. A step is also blocked while the block owns the bus and `wait_in` is high, so the next transfer type is taken only after the previous transfer has finished. The controller has four states:

- **IDLE**: no work is pending.
- **HAND**: the block owns the bus and presents an address-only handover cycle before the first data beat.
- **BEAT**: a data beat is on the bus.
- **PARK**: work is pending but the grant is absent.

The transitions are:

- IDLE→BEAT: a request is accepted while the block already owns the bus.
- IDLE→HAND: a request is accepted while the grant has just arrived.
- IDLE→PARK: a request is accepted with no grant.
- PARK→HAND: the grant arrives.
- HAND→BEAT: the grant is still held.
- HAND→PARK: the grant is lost.
- BEAT→BEAT: the next beat follows.
- BEAT→PARK: the grant is lost between beats.
- BEAT→IDLE: the last beat finishes, or the error input aborts the burst.

The parameter `IS_DEFAULT` picks the ownership at reset.

Top module: `bm_xfer_seq`

## Requirements
- R1: `tran_o` only ever shows 00 (address-only), 10 (nonsequential) or 11 (sequential). The code 01 is never produced.
- R2: While the block owns the bus with no data beat pending, it shows address-only. On every cycle where `bus_oe` rises, `tran_o` is 00, which is the handover cycle.
- R3: A single transfer, and the first beat of a burst, is nonsequential. Each later beat is sequential, at the previous address plus 1, 2 or 4 bytes for byte, halfword or word size.
- R4: `bus_oe` is 1 only while the block owns the bus. Ownership follows `grant` at steps. Ownership is not given up while an owned data beat is held by `wait_in`, and a data type is never shown with `bus_oe` low.
- R5: While the block owns the bus and `wait_in` is high, no output changes.
- R6: `write_o`, `size_o` and `prot_o` carry the request encodings:
  - `write_o`: 0 is read, 1 is write.
  - `size_o`: 00 byte, 01 halfword, 10 word.
  - `prot_o` bit 0: 0 is opcode fetch, 1 is data.
  - `prot_o` bit 1: 0 is user, 1 is privileged.
  A requested size of 11 is issued as word (10), with 4-byte steps.
- R7: While `rst_n` is low, `tran_o` is 00 and `lock_o` is 0. `bus_oe` is 1 for a default master (`IS_DEFAULT`=1) and 0 otherwise. Reset acts asynchronously.
- R8: If the grant is lost between beats, the remaining beats are issued after regrant. They follow a handover cycle and start with a nonsequential beat at the next pending address.
- R9: `resp_last` high at the completion of a beat makes the next beat of that burst nonsequential.
- R10: Each completed beat gives a one-cycle `beat_done`. `resp_err` high at completion sets `beat_err` with it, drops the remaining beats and returns to address-only.
- R11: On an edge with `phase_hi` low, no output register changes.
- R12: `req_ready` is high only in IDLE on a step, and a request is taken when `req_valid` is also high. A beat count of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low reset, asynchronous assert |
| phase_hi | input | 1 | 1 marks an edge where the sequencer may advance |
| grant | input | 1 | bus grant for this master |
| wait_in | input | 1 | slave wait response for the current transfer |
| resp_err | input | 1 | slave error for the completing beat |
| resp_last | input | 1 | slave request to break the burst after this beat |
| req_valid | input | 1 | local request present |
| req_ready | output | 1 | request accepted at this edge if valid |
| req_addr | input | AW | start address |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | beat size code |
| req_prot | input | 2 | protection code |
| req_beats | input | CW | beat count (0 means 1) |
| tran_o | output | 2 | transfer type |
| addr_o | output | AW | transfer address |
| write_o | output | 1 | transfer direction |
| size_o | output | 2 | transfer size |
| prot_o | output | 2 | protection information |
| lock_o | output | 1 | lock output, held low |
| bus_oe | output | 1 | enable for all shared outputs (0 = high impedance) |
| beat_done | output | 1 | a data beat completed at the last edge |
| beat_err | output | 1 | that beat completed with an error |

## Verification
The hardest case to reach is a grant lost in the middle of a burst, while the current beat is still held by the slave. This must neither release the bus early nor drop a beat. The stimulus first waits for a data beat to appear, then forces `wait_in` high and removes the grant. It checks that the enable stays up, then releases the wait and checks that the bus is parked. Finally it restores the grant and checks the handover cycle and the nonsequential restart address. A long closing run also drives grant, wait, last and error from shift-register patterns, so these interleavings recur many times against the cycle-level model.

// File: rtl/bm_seq_pkg.sv
package bm_seq_pkg;

    typedef enum logic [1:0] {
        TR_ADDR_ONLY = 2'b00,
        TR_NSEQ      = 2'b10,
        TR_SEQ       = 2'b11
    } tran_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HAND,
        ST_BEAT,
        ST_PARK
    } state_e;

    // reserved size code is issued as a word
    function automatic logic [1:0] norm_size(input logic [1:0] s);
        return (s == 2'b11) ? 2'b10 : s;
    endfunction

endpackage

// File: rtl/bm_addr_gen.sv
module bm_addr_gen #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          bump,
    input  logic [1:0]    size,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] incr;

    always_comb begin
        incr = AW'(1) << size;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
        end else if (bump) begin
            addr_q <= addr_q + incr;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/bm_beat_ctr.sv
module bm_beat_ctr #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          is_last
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CW'(1);
        end else if (load) begin
            cnt_q <= (load_val == '0) ? CW'(1) : load_val;
        end else if (dec) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign is_last = (cnt_q == CW'(1));
endmodule

// File: rtl/bm_xfer_seq.sv
module bm_xfer_seq
    import bm_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter bit IS_DEFAULT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phase_hi,
    input  logic          grant,
    input  logic          wait_in,
    input  logic          resp_err,
    input  logic          resp_last,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    input  logic          req_write,
    input  logic [1:0]    req_size,
    input  logic [1:0]    req_prot,
    input  logic [CW-1:0] req_beats,
    output logic [1:0]    tran_o,
    output logic [AW-1:0] addr_o,
    output logic          write_o,
    output logic [1:0]    size_o,
    output logic [1:0]    prot_o,
    output logic          lock_o,
    output logic          bus_oe,
    output logic          beat_done,
    output logic          beat_err
);
    state_e state_q, state_d;
    logic   own_q, own_d;
    logic   seq_q, seq_d;
    logic   done_d, err_d;
    logic   write_q, write_d;
    logic [1:0] size_q, size_d;
    logic [1:0] prot_q, prot_d;
    logic   step, load, bump, dec, is_last;

    // an owned transfer held by wait freezes the sequencer
    assign step = phase_hi & ~(own_q & wait_in);

    bm_addr_gen #(.AW(AW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_addr (req_addr),
        .bump      (bump),
        .size      (size_q),
        .addr      (addr_o)
    );

    bm_beat_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (req_beats),
        .dec      (dec),
        .is_last  (is_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        own_d   = own_q;
        seq_d   = seq_q;
        done_d  = 1'b0;
        err_d   = 1'b0;
        load    = 1'b0;
        bump    = 1'b0;
        dec     = 1'b0;
        write_d = write_q;
        size_d  = size_q;
        prot_d  = prot_q;
        if (step) begin
            unique case (state_q)
                ST_IDLE: begin
                    own_d = grant;
                    if (req_valid) begin
                        load    = 1'b1;
                        seq_d   = 1'b0;
                        write_d = req_write;
                        size_d  = norm_size(req_size);
                        prot_d  = req_prot;
                        if (!grant) begin
                            state_d = ST_PARK;
                        end else if (own_q) begin
                            state_d = ST_BEAT;
                        end else begin
                            state_d = ST_HAND;
                        end
                    end
                end
                ST_PARK: begin
                    own_d = grant;
                    if (grant) begin
                        state_d = ST_HAND;
                    end
                end
                ST_HAND: begin
                    own_d   = grant;
                    seq_d   = 1'b0;
                    state_d = grant ? ST_BEAT : ST_PARK;
                end
                ST_BEAT: begin
                    done_d = 1'b1;
                    err_d  = resp_err;
                    if (resp_err || is_last) begin
                        state_d = ST_IDLE;
                        own_d   = grant;
                    end else begin
                        bump = 1'b1;
                        dec  = 1'b1;
                        if (!grant) begin
                            own_d   = 1'b0;
                            state_d = ST_PARK;
                        end else begin
                            seq_d = ~resp_last;
                        end
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            own_q   <= IS_DEFAULT;
            seq_q   <= 1'b0;
            write_q <= 1'b0;
            size_q  <= 2'b00;
            prot_q  <= 2'b00;
            beat_done <= 1'b0;
            beat_err  <= 1'b0;
        end else begin
            state_q <= state_d;
            own_q   <= own_d;
            seq_q   <= seq_d;
            write_q <= write_d;
            size_q  <= size_d;
            prot_q  <= prot_d;
            beat_done <= done_d;
            beat_err  <= err_d;
        end
    end

    // outputs
    always_comb begin
        tran_o    = TR_ADDR_ONLY;
        if (state_q == ST_BEAT) begin
            tran_o = seq_q ? TR_SEQ : TR_NSEQ;
        end
        bus_oe    = own_q;
        lock_o    = 1'b0;
        write_o   = write_q;
        size_o    = size_q;
        prot_o    = prot_q;
        req_ready = (state_q == ST_IDLE) & step;
    end
endmodule

// File: rtl/bm_xfer_seq_chk.sv
module bm_xfer_seq_chk #(
    parameter int AW         = 32,
    parameter bit IS_DEFAULT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          phase_hi,
    input logic          wait_in,
    input logic [1:0]    tran_o,
    input logic [AW-1:0] addr_o,
    input logic [1:0]    size_o,
    input logic          lock_o,
    input logic          bus_oe,
    input logic          beat_done,
    input logic          beat_err
);
    logic [AW-1:0] inc_w;
    assign inc_w = AW'(1) << size_o;

    p_no_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tran_o != 2'b01);

    p_handover_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> tran_o == 2'b00);

    p_seq_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && tran_o == 2'b11) |-> addr_o == $past(addr_o) + inc_w);

    p_data_owned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tran_o[1] |-> bus_oe);

    p_wait_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && wait_in) |=> ($stable(tran_o) && $stable(addr_o) && $stable(bus_oe)));

    p_size_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tran_o[1] |-> size_o != 2'b11);

    p_err_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        beat_err |-> (beat_done && tran_o == 2'b00));

    p_phase_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_hi |=> ($stable(tran_o) && $stable(bus_oe) && !beat_done));

    // R7: reset state
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_state_r7: assert (tran_o == 2'b00 && !lock_o && bus_oe == IS_DEFAULT);
        end
    end
endmodule

bind bm_xfer_seq bm_xfer_seq_chk #(.AW(AW), .IS_DEFAULT(IS_DEFAULT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_hi  (phase_hi),
    .wait_in   (wait_in),
    .tran_o    (tran_o),
    .addr_o    (addr_o),
    .size_o    (size_o),
    .lock_o    (lock_o),
    .bus_oe    (bus_oe),
    .beat_done (beat_done),
    .beat_err  (beat_err)
);

// File: tb/bm_xfer_seq_tb.sv
module bm_xfer_seq_tb;
    localparam int AW = 32;
    localparam int CW = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b1;
    logic phase_hi = 1'b0;
    logic phase_hold = 1'b0;
    logic grant_man = 1'b1, wait_force = 1'b0, err_force = 1'b0, last_force = 1'b0;
    logic rand_en = 1'b0;
    logic [7:0]  lf = 8'hA5;
    logic [15:0] lg = 16'hACE1;
    logic grant, wait_in, resp_err, resp_last;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_size = 2'b00, req_prot = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [CW-1:0] req_beats = '0;

    logic req_ready, write_o, lock_o, bus_oe, beat_done, beat_err;
    logic [1:0] tran_o, size_o, prot_o;
    logic [AW-1:0] addr_o;
    logic rdy2, wr2, lk2, oe2, bd2, be2;
    logic [1:0] tr2, sz2, pr2;
    logic [AW-1:0] ad2;

    always @(posedge clk) begin
        if (!phase_hold) phase_hi <= ~phase_hi;
        lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        lg <= {lg[14:0], lg[15] ^ lg[13] ^ lg[12] ^ lg[10]};
    end

    assign grant     = grant_man & ~(rand_en & lg[0] & lg[3]);
    assign wait_in   = wait_force | (rand_en & lf[0] & lf[1]);
    assign resp_last = last_force | (rand_en & lf[2] & lf[5] & lf[6]);
    assign resp_err  = err_force  | (rand_en & lf[3] & lf[4] & lf[6] & lf[7] & lg[5]);

    bm_xfer_seq #(.AW(AW), .CW(CW), .IS_DEFAULT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .grant(grant), .wait_in(wait_in),
        .resp_err(resp_err), .resp_last(resp_last), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size), .req_prot(req_prot),
        .req_beats(req_beats), .tran_o(tran_o), .addr_o(addr_o), .write_o(write_o),
        .size_o(size_o), .prot_o(prot_o), .lock_o(lock_o), .bus_oe(bus_oe),
        .beat_done(beat_done), .beat_err(beat_err));

    bm_xfer_seq #(.AW(AW), .CW(CW), .IS_DEFAULT(1'b0)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .grant(1'b0), .wait_in(wait_in),
        .resp_err(resp_err), .resp_last(resp_last), .req_valid(1'b0), .req_ready(rdy2),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size), .req_prot(req_prot),
        .req_beats(req_beats), .tran_o(tr2), .addr_o(ad2), .write_o(wr2),
        .size_o(sz2), .prot_o(pr2), .lock_o(lk2), .bus_oe(oe2),
        .beat_done(bd2), .beat_err(be2));

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference: mode 0 idle, 1 handover, 2 data beat, 3 parked
    int m_mode = 0;
    bit m_own = 1'b1, m_seq = 1'b0, m_done = 1'b0, m_err = 1'b0;
    logic [AW-1:0] m_q[$];
    logic m_wr = 1'b0;
    logic [1:0] m_sz = 2'b00, m_pr = 2'b00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_own = 1'b1; m_seq = 1'b0; m_done = 1'b0; m_err = 1'b0;
            m_q.delete();
        end else begin
            bit st;
            bit was_own;
            st = phase_hi && !(m_own && wait_in);
            was_own = m_own;
            m_done = 1'b0; m_err = 1'b0;
            if (st) begin
                case (m_mode)
                    0: begin
                        m_own = grant;
                        if (req_valid) begin
                            int n;
                            n = (req_beats == 0) ? 1 : int'(req_beats);
                            m_sz = (req_size == 2'b11) ? 2'b10 : req_size;
                            m_wr = req_write; m_pr = req_prot; m_seq = 1'b0;
                            for (int i = 0; i < n; i++) m_q.push_back(req_addr + AW'(i * (1 << m_sz)));
                            m_mode = !grant ? 3 : (was_own ? 2 : 1);
                        end
                    end
                    3: begin m_own = grant; if (grant) m_mode = 1; end
                    1: begin m_own = grant; m_seq = 1'b0; m_mode = grant ? 2 : 3; end
                    default: begin
                        m_done = 1'b1; m_err = resp_err;
                        void'(m_q.pop_front());
                        if (resp_err) begin m_q.delete(); m_mode = 0; m_own = grant; end
                        else if (m_q.size() == 0) begin m_mode = 0; m_own = grant; end
                        else if (!grant) begin m_own = 1'b0; m_mode = 3; end
                        else m_seq = !resp_last;
                    end
                endcase
            end
        end
    end

    // per-cycle comparison and beat counting
    int n_nseq = 0, n_seq = 0;
    bit prev_data = 1'b0, err_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            logic [1:0] et;
            bit er;
            et = (m_mode == 2) ? (m_seq ? 2'b11 : 2'b10) : 2'b00;
            er = (m_mode == 0) && phase_hi && !(m_own && wait_in);
            chk(tran_o == et, "R3 transfer type", tran_o, et);
            chk(tran_o != 2'b01, "R1 no reserved type", tran_o, 0);
            chk(bus_oe == m_own, "R4 bus enable", bus_oe, m_own);
            chk(lock_o == 1'b0, "R7 lock low", lock_o, 0);
            chk(beat_done == m_done, "R10 beat done", beat_done, m_done);
            chk(beat_err == m_err, "R10 beat error", beat_err, m_err);
            chk(req_ready == er, "R12 ready", req_ready, er);
            if (et[1] && m_q.size() > 0) begin
                chk(addr_o == m_q[0], "R3 address", addr_o, m_q[0]);
                chk(write_o == m_wr, "R6 direction", write_o, m_wr);
                chk(size_o == m_sz, "R6 size", size_o, m_sz);
                chk(prot_o == m_pr, "R6 protection", prot_o, m_pr);
            end
            if (tran_o[1] && (!prev_data || beat_done)) begin
                if (tran_o == 2'b11) n_seq++; else n_nseq++;
            end
            if (beat_err) err_seen = 1'b1;
            prev_data = tran_o[1];
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [AW-1:0] a, input logic w, input logic [1:0] s,
                         input logic [1:0] p, input logic [CW-1:0] b);
        bit got;
        int guard;
        req_addr = a; req_write = w; req_size = s; req_prot = p; req_beats = b;
        req_valid = 1'b1;
        got = 1'b0; guard = 0;
        while (!got && guard < 5000) begin
            @(negedge clk);
            got = req_ready;
            @(posedge clk); #1;
            guard++;
        end
        req_valid = 1'b0;
        chk(got, "R12 request accepted", got, 1);
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        @(negedge clk);
        while (m_mode != 0 && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(m_mode == 0, "R8 burst drained", m_mode, 0);
        cycles(2);
    endtask

    task automatic clr();
        n_nseq = 0; n_seq = 0; err_seen = 1'b0;
    endtask

    task automatic wait_data();
        int guard;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!tran_o[1] && guard < 5000);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [1:0] t0;
        logic [AW-1:0] a0;
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tran_o == 2'b00 && bus_oe && !lock_o, "R7 default master reset", {tran_o, bus_oe, lock_o}, 4'b0010);
        chk(tr2 == 2'b00 && !oe2 && !lk2, "R7 non-default reset", {tr2, oe2, lk2}, 4'b0000);
        while (phase_hi) @(negedge clk);
        rst_n = 1'b1;
        cycles(4);
        @(negedge clk);
        chk(tran_o == 2'b00 && bus_oe, "R2 idle owned address-only", {tran_o, bus_oe}, 3'b001);

        clr(); issue(32'h100, 1'b0, 2'b00, 2'b01, 5'd1); drain();
        chk(n_nseq == 1 && n_seq == 0, "R3 single nonsequential", {n_nseq, n_seq}, {32'd1, 32'd0});

        clr(); issue(32'h1000, 1'b1, 2'b10, 2'b11, 5'd4); drain();
        chk(n_nseq == 1 && n_seq == 3, "R3 word burst", {n_nseq, n_seq}, {32'd1, 32'd3});

        // stalls from random wait only
        clr();
        fork begin
            for (int i = 0; i < 200; i++) begin @(posedge clk); #1; wait_force = lf[0] & lf[2]; end
            wait_force = 1'b0;
        end join_none
        issue(32'h2002, 1'b0, 2'b01, 2'b10, 5'd5); drain();
        wait fork;
        wait_force = 1'b0;
        chk(n_nseq == 1 && n_seq == 4, "R5 waits keep burst", {n_nseq, n_seq}, {32'd1, 32'd4});
        cycles(2);

        // grant removed while a beat waits
        clr();
        issue(32'h3000, 1'b1, 2'b10, 2'b00, 5'd3);
        wait_data();
        @(posedge clk); #1; wait_force = 1'b1;
        @(negedge clk); t0 = tran_o; a0 = addr_o;
        @(posedge clk); #1; grant_man = 1'b0;
        cycles(6);
        @(negedge clk);
        chk(tran_o == t0 && addr_o == a0, "R5 held during wait", {tran_o, addr_o}, {t0, a0});
        chk(bus_oe == 1'b1, "R4 bus kept while waiting", bus_oe, 1);
        @(posedge clk); #1; wait_force = 1'b0;
        cycles(6);
        @(negedge clk);
        chk(bus_oe == 1'b0 && tran_o == 2'b00, "R4 released after grant loss", {bus_oe, tran_o}, 0);
        @(posedge clk); #1; grant_man = 1'b1;
        do @(negedge clk); while (!bus_oe);
        chk(tran_o == 2'b00, "R2 handover cycle", tran_o, 0);
        wait_data();
        chk(tran_o == 2'b10 && addr_o == 32'h3004, "R8 restart nonsequential", {tran_o, addr_o}, {2'b10, 32'h3004});
        drain();

        clr(); last_force = 1'b1;
        issue(32'h4000, 1'b0, 2'b10, 2'b10, 5'd3); drain();
        last_force = 1'b0;
        chk(n_nseq == 3 && n_seq == 0, "R9 break to nonsequential", {n_nseq, n_seq}, {32'd3, 32'd0});

        clr(); err_force = 1'b1;
        issue(32'h5000, 1'b1, 2'b00, 2'b11, 5'd5); drain();
        err_force = 1'b0;
        chk(n_nseq == 1 && n_seq == 0 && err_seen, "R10 error abort", {n_nseq, n_seq, err_seen}, {32'd1, 32'd0, 1'b1});

        clr(); issue(32'h6000, 1'b1, 2'b11, 2'b01, 5'd2);
        wait_data();
        chk(size_o == 2'b10, "R6 reserved size as word", size_o, 2'b10);
        drain();
        chk(n_nseq == 1 && n_seq == 1, "R6 reserved size burst", {n_nseq, n_seq}, {32'd1, 32'd1});

        clr(); issue(32'h7000, 1'b0, 2'b00, 2'b00, 5'd0); drain();
        chk(n_nseq == 1 && n_seq == 0, "R12 zero count is one beat", {n_nseq, n_seq}, {32'd1, 32'd0});

        // phase held low: nothing may move
        do begin @(posedge clk); #1; end while (phase_hi);
        phase_hold = 1'b1;
        req_addr = 32'h8000; req_beats = 5'd2; req_size = 2'b10; req_valid = 1'b1;
        cycles(6);
        @(negedge clk);
        chk(tran_o == 2'b00 && !req_ready && bus_oe, "R11 no change without phase", {tran_o, req_ready, bus_oe}, 4'b0001);
        @(posedge clk); #1; phase_hold = 1'b0; req_valid = 1'b0;
        clr(); issue(32'h8000, 1'b0, 2'b10, 2'b00, 5'd2); drain();

        // mixed traffic
        rand_en = 1'b1;
        for (int k = 0; k < 60; k++) begin
            logic [31:0] r;
            r = $urandom;
            issue({r[31:8], 8'h00}, r[0], r[2:1], r[4:3], CW'(r[8:5]));
        end
        drain();
        rand_en = 1'b0;
        drain();

        summary();
        $finish;
    end
endmodule